// File: doc/BRIEF.md
# Translation fault status reporter

This block sits beside an I/O address translation unit and records what went wrong when a device access cannot be translated. The translation walker presents a one-cycle fault pulse together with the fault class (segment or page), the page address of the access, whether it was a read or a write, and the identifier of the requesting device. The block latches the first such fault into a 64-bit status word and holds it until software acknowledges it. Faults that arrive while a report is pending are dropped, so the earliest cause is kept.

A second register holds one interrupt enable for each fault class. The interrupt output is a level. It is high while a report is pending and the enable for the captured class is set. Software reads the status word through a simple register port. It acknowledges the report by writing the word back with the top bit cleared, then waits for the next fault.

Top module: `xfr_fault_report`

## Requirements
- R1: After synchronous reset the status word, the enable register, `irq` and `reg_rdata` are all zero.
- R2: When no report is pending, a fault pulse is captured at the next clock edge. The status word then reads: bit 63 = 1 (pending), bits 62:61 = 2'b11 for a segment fault or 2'b10 for a page fault, bits 34:12 = page address, bit 11 = direction (1 read, 0 write), bits 10:0 = device ID, and all other bits 0.
- R3: While a report is pending and no acknowledge is written, further fault pulses leave the status word unchanged.
- R4: A write to the status register (`reg_sel` = 0) with bit 63 = 0 clears the pending bit. A status write never changes any other field, and a status write with bit 63 = 1 has no effect.
- R5: A fault pulse in the same cycle as an acknowledge write is captured. The status word after that edge holds the new fault with bit 63 set.
- R6: A write to the enable register (`reg_sel` = 1) stores bit 62 as the segment-fault enable and bit 61 as the page-fault enable. A read of this register returns those two bits in place, with all other bits 0.
- R7: `irq` is high exactly when a report is pending and the enable for the captured fault class is set. It changes on the same clock edge as the status or enable register that causes the change.
- R8: With `reg_rd` high, `reg_rdata` loads at the clock edge the value the selected register held before that edge. With `reg_rd` low, `reg_rdata` holds its value.
- R9: `irq` falls on the edge that takes an acknowledge write, or on the edge that takes an enable write turning off the captured class's enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_valid | input | 1 | One-cycle fault pulse from the walker |
| flt_seg | input | 1 | 1 = segment fault, 0 = page fault |
| flt_rd | input | 1 | 1 = faulting access was a read |
| flt_page | input | PAGE_W | Page address of the faulting access |
| flt_id | input | ID_W | Requesting device identifier |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 1 | 0 = status word, 1 = enable register |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Registered read data |
| irq | output | 1 | Level interrupt |

## Verification
On every cycle, the assertions check the following: capture into an idle register, preservation of a pending report, clearing by an acknowledge with and without a coincident fault, `irq` never high without a pending report, and the reset state. The bench's scenarios alone show the field layout of the captured word, which enable bit controls which class, the same-edge timing of `irq`, the masking of unused enable bits and the read latency. To do this the bench sweeps every enable setting against both classes and both directions.

// File: rtl/xfr_pkg.sv
package xfr_pkg;
  localparam int WORD_W    = 64;
  localparam int PEND_BIT  = 63;
  localparam int KIND_HI   = 62;
  localparam int KIND_LO   = 61;
  localparam int EN_SEG    = 62;
  localparam int EN_PAGE   = 61;
  localparam logic [1:0] KIND_SEG  = 2'b11;
  localparam logic [1:0] KIND_PAGE = 2'b10;

  typedef enum logic {SEL_STATUS = 1'b0, SEL_ENABLE = 1'b1} reg_sel_e;
endpackage

// File: rtl/xfr_capture.sv
module xfr_capture #(
  parameter int PAGE_W = 23,
  parameter int ID_W   = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flt_valid,
  input  logic              flt_seg,
  input  logic              flt_rd,
  input  logic [PAGE_W-1:0] flt_page,
  input  logic [ID_W-1:0]   flt_id,
  input  logic              ack,
  output logic              pend_q,
  output logic [1:0]        kind_q,
  output logic              dir_q,
  output logic [PAGE_W-1:0] page_q,
  output logic [ID_W-1:0]   id_q,
  output logic              pend_nxt,
  output logic              seg_nxt
);
  import xfr_pkg::*;

  logic take;

  always_comb begin
    take     = flt_valid && (!pend_q || ack);
    pend_nxt = take ? 1'b1 : (ack ? 1'b0 : pend_q);
    seg_nxt  = take ? flt_seg : kind_q[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      kind_q <= 2'b00;
      dir_q  <= 1'b0;
      page_q <= '0;
      id_q   <= '0;
    end else begin
      pend_q <= pend_nxt;
      if (take) begin
        kind_q <= flt_seg ? KIND_SEG : KIND_PAGE;
        dir_q  <= flt_rd;
        page_q <= flt_page;
        id_q   <= flt_id;
      end
    end
  end
endmodule

// File: rtl/xfr_enable.sv
module xfr_enable (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic [1:0] wbits,
  output logic       en_seg_q,
  output logic       en_pg_q,
  output logic       en_seg_nxt,
  output logic       en_pg_nxt
);
  always_comb begin
    en_seg_nxt = wr ? wbits[1] : en_seg_q;
    en_pg_nxt  = wr ? wbits[0] : en_pg_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_seg_q <= 1'b0;
      en_pg_q  <= 1'b0;
    end else begin
      en_seg_q <= en_seg_nxt;
      en_pg_q  <= en_pg_nxt;
    end
  end
endmodule

// File: rtl/xfr_irq.sv
module xfr_irq (
  input  logic clk,
  input  logic rst,
  input  logic pend_nxt,
  input  logic seg_nxt,
  input  logic en_seg_nxt,
  input  logic en_pg_nxt,
  output logic irq_q
);
  logic fire;

  always_comb fire = pend_nxt && (seg_nxt ? en_seg_nxt : en_pg_nxt);

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= fire;
  end
endmodule

// File: rtl/xfr_fault_report.sv
module xfr_fault_report #(
  parameter int PAGE_W = 23,
  parameter int ID_W   = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flt_valid,
  input  logic              flt_seg,
  input  logic              flt_rd,
  input  logic [PAGE_W-1:0] flt_page,
  input  logic [ID_W-1:0]   flt_id,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic              reg_sel,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  output logic              irq
);
  import xfr_pkg::*;

  localparam int DIR_POS  = ID_W;
  localparam int PAGE_LSB = ID_W + 1;

  logic              ack;
  logic              en_wr;
  logic              pend_q;
  logic [1:0]        kind_q;
  logic              dir_q;
  logic [PAGE_W-1:0] page_q;
  logic [ID_W-1:0]   id_q;
  logic              pend_nxt;
  logic              seg_nxt;
  logic              en_seg_q;
  logic              en_pg_q;
  logic              en_seg_nxt;
  logic              en_pg_nxt;
  logic [63:0]       stat_word;
  logic [63:0]       en_word;

  always_comb begin
    ack   = reg_wr && (reg_sel == SEL_STATUS) && !reg_wdata[PEND_BIT];
    en_wr = reg_wr && (reg_sel == SEL_ENABLE);
  end

  xfr_capture #(.PAGE_W(PAGE_W), .ID_W(ID_W)) u_cap (
    .clk(clk), .rst(rst),
    .flt_valid(flt_valid), .flt_seg(flt_seg), .flt_rd(flt_rd),
    .flt_page(flt_page), .flt_id(flt_id), .ack(ack),
    .pend_q(pend_q), .kind_q(kind_q), .dir_q(dir_q),
    .page_q(page_q), .id_q(id_q),
    .pend_nxt(pend_nxt), .seg_nxt(seg_nxt)
  );

  xfr_enable u_en (
    .clk(clk), .rst(rst), .wr(en_wr),
    .wbits({reg_wdata[EN_SEG], reg_wdata[EN_PAGE]}),
    .en_seg_q(en_seg_q), .en_pg_q(en_pg_q),
    .en_seg_nxt(en_seg_nxt), .en_pg_nxt(en_pg_nxt)
  );

  xfr_irq u_irq (
    .clk(clk), .rst(rst),
    .pend_nxt(pend_nxt), .seg_nxt(seg_nxt),
    .en_seg_nxt(en_seg_nxt), .en_pg_nxt(en_pg_nxt),
    .irq_q(irq)
  );

  always_comb begin
    stat_word = '0;
    stat_word[PEND_BIT] = pend_q;
    stat_word[KIND_HI:KIND_LO] = kind_q;
    stat_word[PAGE_LSB +: PAGE_W] = page_q;
    stat_word[DIR_POS] = dir_q;
    stat_word[ID_W-1:0] = id_q;
    en_word = '0;
    en_word[EN_SEG]  = en_seg_q;
    en_word[EN_PAGE] = en_pg_q;
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= (reg_sel == SEL_ENABLE) ? en_word : stat_word;
  end
endmodule

// File: rtl/xfr_fault_report_chk.sv
module xfr_fault_report_chk (
  input logic        clk,
  input logic        rst,
  input logic        flt_valid,
  input logic        reg_wr,
  input logic        reg_sel,
  input logic        wbit63,
  input logic [63:0] stat_word,
  input logic        irq
);
  logic ack_w;
  always_comb ack_w = reg_wr && !reg_sel && !wbit63;

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (stat_word == 64'd0 && !irq));
  // R2
  idle_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (!stat_word[63] && flt_valid) |=> stat_word[63]);
  // R3
  first_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_word[63] && !ack_w) |=> $stable(stat_word));
  // R4
  ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_w && !flt_valid) |=> !stat_word[63]);
  // R5
  ack_and_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_w && flt_valid) |=> stat_word[63]);
  // R7
  irq_needs_pend_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> stat_word[63]);
endmodule

bind xfr_fault_report xfr_fault_report_chk u_chk (
  .clk(clk), .rst(rst), .flt_valid(flt_valid), .reg_wr(reg_wr),
  .reg_sel(reg_sel), .wbit63(reg_wdata[63]), .stat_word(stat_word), .irq(irq)
);

// File: tb/xfr_fault_report_test.sv
module xfr_fault_report_test;
  localparam int PAGE_W = 23;
  localparam int ID_W   = 11;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              flt_valid = 1'b0;
  logic              flt_seg = 1'b0;
  logic              flt_rd = 1'b0;
  logic [PAGE_W-1:0] flt_page = '0;
  logic [ID_W-1:0]   flt_id = '0;
  logic              reg_wr = 1'b0;
  logic              reg_rd = 1'b0;
  logic              reg_sel = 1'b0;
  logic [63:0]       reg_wdata = '0;
  logic [63:0]       reg_rdata;
  logic              irq;

  int checks = 0;
  int errors = 0;

  xfr_fault_report #(.PAGE_W(PAGE_W), .ID_W(ID_W)) uut (
    .clk(clk), .rst(rst), .flt_valid(flt_valid), .flt_seg(flt_seg),
    .flt_rd(flt_rd), .flt_page(flt_page), .flt_id(flt_id),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  always #2 clk = ~clk;

  function automatic logic [63:0] word(input logic v, input logic s, input logic r,
                                       input logic [PAGE_W-1:0] p, input logic [ID_W-1:0] id);
    logic [63:0] w;
    w = '0;
    w[63] = v;
    w[62] = 1'b1;
    w[61] = s;
    w[34:12] = p;
    w[11] = r;
    w[10:0] = id;
    return w;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fault(input logic s, input logic r, input logic [PAGE_W-1:0] p,
                       input logic [ID_W-1:0] id);
    flt_valid = 1'b1; flt_seg = s; flt_rd = r; flt_page = p; flt_id = id;
    tick();
    flt_valid = 1'b0;
  endtask

  task automatic wr(input logic sel, input logic [63:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [63:0] d);
    reg_rd = 1'b1; reg_sel = sel;
    tick();
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  initial begin
    #600000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] d;
    logic [63:0] hold;
    repeat (3) tick();
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq", {63'd0, irq}, 64'd0);
    chk("R1 rdata", reg_rdata, 64'd0);
    rd(1'b0, d); chk("R1 status", d, 64'd0);
    rd(1'b1, d); chk("R1 enable", d, 64'd0);

    // R6 unused enable bits read zero
    wr(1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(1'b1, d); chk("R6 enable all-ones", d, 64'h6000_0000_0000_0000);

    // sweep enables x class x direction x patterns
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 2; s++) begin
        for (int r = 0; r < 2; r++) begin
          for (int k = 0; k < 4; k++) begin
            logic [PAGE_W-1:0] p;
            logic [ID_W-1:0] id;
            logic en;
            p  = PAGE_W'((k * 32'h12345 + m * 7 + s * 3) ^ (k == 3 ? 32'h7FFFFF : 0));
            id = ID_W'(k * 32'h155 + m + r * 2);
            en = s ? m[1] : m[0];
            wr(1'b1, {1'b0, m[1], m[0], 61'd0});
            rd(1'b1, d); chk("R6 enable readback", d, {1'b0, m[1], m[0], 61'd0});
            fault(s[0], r[0], p, id);
            // R7 irq with the status update
            chk("R7 irq after capture", {63'd0, irq}, {63'd0, en});
            rd(1'b0, d); chk("R2 captured word", d, word(1'b1, s[0], r[0], p, id));
            // R3 later fault dropped
            fault(~s[0], ~r[0], ~p, ~id);
            rd(1'b0, d); chk("R3 first kept", d, word(1'b1, s[0], r[0], p, id));
            // R4 ack, other bits ignored
            wr(1'b0, 64'h7FFF_FFFF_FFFF_FFFF);
            chk("R9 irq after ack", {63'd0, irq}, 64'd0);
            rd(1'b0, d); chk("R4 cleared", d, word(1'b0, s[0], r[0], p, id));
          end
        end
      end
    end

    // R4 write with bit 63 set has no effect while idle
    wr(1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(1'b0, d); chk("R4 set ignored", {63'd0, d[63]}, 64'd0);

    // R5 fault together with ack
    wr(1'b1, 64'h6000_0000_0000_0000);
    fault(1'b0, 1'b1, 23'h0ABCDE, 11'h123);
    flt_valid = 1'b1; flt_seg = 1'b1; flt_rd = 1'b0; flt_page = 23'h654321; flt_id = 11'h7AB;
    reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 64'd0;
    tick();
    flt_valid = 1'b0; reg_wr = 1'b0;
    chk("R5 irq", {63'd0, irq}, 64'd1);
    rd(1'b0, d); chk("R5 new fault kept", d, word(1'b1, 1'b1, 1'b0, 23'h654321, 11'h7AB));

    // R9 enable write turns irq off
    wr(1'b1, 64'h2000_0000_0000_0000);
    chk("R9 irq after disable", {63'd0, irq}, 64'd0);
    // R7 re-enable raises irq on same edge
    wr(1'b1, 64'h4000_0000_0000_0000);
    chk("R7 irq after enable", {63'd0, irq}, 64'd1);

    // R8 rdata holds without read strobe
    rd(1'b1, d);
    hold = d;
    wr(1'b1, 64'd0);
    tick();
    chk("R8 rdata hold", reg_rdata, hold);
    chk("R8 hold value", hold, 64'h4000_0000_0000_0000);

    // R1 reset again with pending report
    rst = 1'b1; tick(); rst = 1'b0;
    chk("R1 irq after reset", {63'd0, irq}, 64'd0);
    rd(1'b0, d); chk("R1 status after reset", d, 64'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule